// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block turns a 32-bit virtual data address into a physical address. It looks the address up in a set-associative array of cached page translations. Each lookup strobe carries four inputs: the address, a write flag, a privilege flag and a translation-enable flag. One clock later the block returns four things. They are the physical address, a cache-inhibit flag, a hit flag and single-cycle exception pulses for a protection fault or a missing translation. A miss is never refilled in hardware. The miss pulse carries the faulting address out, and a software handler installs the entry through a register-style port. The port addresses one way of one set.

The same port reads entries back and reports a geometry word. A probe variant of the lookup finds a translation for debug or address peeking. It leaves the replacement state untouched and raises no exception. The default build has 4 KB pages, 64 sets, 2 ways and four usage states per way.

Top module: `dtlb_top`

## Requirements
- R1: With `lk_xlate_en` low, a lookup returns `rs_paddr` equal to the virtual address and `rs_cinh` equal to its bit 31. It also returns `rs_hit`, `rs_pgfault` and `rs_miss` low.
- R2: The set is chosen by virtual bits [17:12] and the compared tag is virtual bits [31:18]. A stored tag in another set never hits.
- R3: A way hits only when its stored tag equals the lookup tag and its valid bit is set. In the match word, the tag sits in bits [31:18] and the valid bit in bit 0. A lookup that reaches only invalid entries is a miss.
- R4: When several ways of a set match, the highest-numbered way provides the translation.
- R5: On a hit, `rs_paddr` is the stored page number followed by virtual bits [11:0], and `rs_cinh` is the stored inhibit bit. In the translate word, the page number sits in bits [31:12], inhibit in bit 1, user read in bit 2, user write in bit 3, supervisor read in bit 4 and supervisor write in bit 5.
- R6: With `lk_super` high, the access needs the supervisor bit for its direction (write or read). With `lk_super` low it needs the user bit. A missing permission gives a hit with `rs_pgfault` high and `rs_fault_addr` equal to the virtual address.
- R7: A miss with translation on raises `rs_miss` and returns `rs_fault_addr` equal to the virtual address, with `rs_hit` low and `rs_paddr` zero.
- R8: A non-probe hit sets the hit way's usage counter (match word bits [2:1]) to 3. Every other way in the set with a nonzero counter drops by one, and a counter at zero stays at zero.
- R9: A probe (`lk_probe` high) raises no exception and leaves usage counters unchanged. On a miss or a permission failure it returns all outputs zero except `rs_valid`.
- R10: Results appear on the cycle after the strobe, with `rs_valid` high for that one cycle. The exception pulses last one cycle.
- R11: A software write changes translations for lookups strobed on the next cycle or later. A lookup in the same cycle as the write sees the old entry.
- R12: Reading with `sw_sel` = 2 returns the geometry word. This word holds log2 of the set count in bits [3:0] and the way count minus one in bits [5:4], which gives 0x16 by default. Selects 0 and 1 read back the addressed match and translate words.
- R13: Reset clears every entry to invalid with zero counters and drives all result outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | Access is a store |
| lk_super | input | 1 | Supervisor privilege |
| lk_xlate_en | input | 1 | Translation enabled |
| lk_probe | input | 1 | Non-faulting probe lookup |
| rs_valid | output | 1 | Result valid (one cycle after strobe) |
| rs_hit | output | 1 | Translation found |
| rs_paddr | output | 32 | Physical address |
| rs_cinh | output | 1 | Cache inhibit |
| rs_pgfault | output | 1 | Protection fault pulse |
| rs_miss | output | 1 | Translation miss pulse |
| rs_fault_addr | output | 32 | Virtual address of the exception, else zero |
| sw_we | input | 1 | Entry write strobe |
| sw_sel | input | 2 | 0 match word, 1 translate word, 2 geometry |
| sw_way | input | 1 | Way addressed |
| sw_set | input | 6 | Set addressed |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data for the addressed word |

## Verification
The tests cover each privilege and direction pair against entries with mixed permission bits, so that each permission bit is tied to its own case. Tag mismatches, set mismatches and cleared valid bits each lead to a miss. Two valid ways holding the same tag show which way wins. The same addresses are also sent as probes and with translation off, which separates the fault and miss paths from the quiet paths. A chain of hits on one set is followed by read-backs of the usage counters, which show the decrement, the reload and saturation at zero. Between these hits, a probe shows that it leaves the counters alone.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int SET_BITS  = 6;
  localparam int NUM_WAYS  = 2;
  localparam int USTATES   = 4;
  localparam bit MMU_PRESENT = 1'b1;

  localparam int NUM_SETS = 1 << SET_BITS;
  localparam int LRU_W    = (USTATES > 2) ? 2 : 1;
  localparam int TAG_W    = VA_W - PAGE_BITS - SET_BITS;
  localparam int PPN_W    = VA_W - PAGE_BITS;
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  localparam logic [1:0] SEL_MATCH = 2'd0;
  localparam logic [1:0] SEL_XLAT  = 2'd1;
  localparam logic [1:0] SEL_GEOM  = 2'd2;

  localparam int M_VALID = 0;
  localparam int M_LRU   = 1;
  localparam int X_CI    = 1;
  localparam int X_URE   = 2;
  localparam int X_UWE   = 3;
  localparam int X_SRE   = 4;
  localparam int X_SWE   = 5;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             valid;
    logic [LRU_W-1:0] lru;
  } mtch_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             ci;
    logic             ure;
    logic             uwe;
    logic             sre;
    logic             swe;
  } xlat_t;

  function automatic logic [VA_W-1:0] mtch_to_word(mtch_t m);
    logic [VA_W-1:0] w;
    w = '0;
    w[VA_W-1 -: TAG_W] = m.tag;
    w[M_LRU +: LRU_W]  = m.lru;
    w[M_VALID]         = m.valid;
    return w;
  endfunction

  function automatic mtch_t word_to_mtch(logic [VA_W-1:0] w);
    mtch_t m;
    m.tag   = w[VA_W-1 -: TAG_W];
    m.lru   = w[M_LRU +: LRU_W];
    m.valid = w[M_VALID];
    return m;
  endfunction

  function automatic logic [VA_W-1:0] xlat_to_word(xlat_t x);
    logic [VA_W-1:0] w;
    w = '0;
    w[VA_W-1 -: PPN_W] = x.ppn;
    w[X_CI]  = x.ci;
    w[X_URE] = x.ure;
    w[X_UWE] = x.uwe;
    w[X_SRE] = x.sre;
    w[X_SWE] = x.swe;
    return w;
  endfunction

  function automatic xlat_t word_to_xlat(logic [VA_W-1:0] w);
    xlat_t x;
    x.ppn = w[VA_W-1 -: PPN_W];
    x.ci  = w[X_CI];
    x.ure = w[X_URE];
    x.uwe = w[X_UWE];
    x.sre = w[X_SRE];
    x.swe = w[X_SWE];
    return x;
  endfunction

  function automatic logic [VA_W-1:0] geom_word();
    logic [VA_W-1:0] w;
    w = '0;
    w[3:0] = 4'(SET_BITS);
    w[5:4] = 2'(NUM_WAYS - 1);
    return w;
  endfunction
endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  input  logic                upd_en,
  input  logic [WAY_W-1:0]    upd_way,
  input  logic                sw_we,
  input  logic [1:0]          sw_sel,
  input  logic [WAY_W-1:0]    sw_way,
  input  logic [SET_BITS-1:0] sw_set,
  input  logic [VA_W-1:0]     sw_wdata,
  output mtch_t               row_m [NUM_WAYS],
  output xlat_t               row_x [NUM_WAYS],
  output logic [VA_W-1:0]     sw_rdata
);
  logic [VA_W-1:0] rd_m [NUM_WAYS];
  logic [VA_W-1:0] rd_x [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    mtch_t            m_q [NUM_SETS];
    xlat_t            x_q [NUM_SETS];
    logic [LRU_W-1:0] lru_cur;
    logic [LRU_W-1:0] lru_nxt;
    logic             m_we;
    logic             x_we;

    assign lru_cur = m_q[rd_set].lru;

    // usage counter next value for the set being looked up
    always_comb begin
      if (upd_way == WAY_W'(w))
        lru_nxt = LRU_W'(USTATES - 1);
      else if (lru_cur != '0)
        lru_nxt = lru_cur - 1'b1;
      else
        lru_nxt = '0;
    end

    assign m_we = sw_we && (sw_way == WAY_W'(w)) && (sw_sel == SEL_MATCH);
    assign x_we = sw_we && (sw_way == WAY_W'(w)) && (sw_sel == SEL_XLAT);

    // software write is placed last so it wins a same-entry collision
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < NUM_SETS; s++) m_q[s] <= '0;
      end else begin
        if (upd_en) m_q[rd_set].lru <= lru_nxt;
        if (m_we)   m_q[sw_set]     <= word_to_mtch(sw_wdata);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < NUM_SETS; s++) x_q[s] <= '0;
      end else if (x_we) begin
        x_q[sw_set] <= word_to_xlat(sw_wdata);
      end
    end

    assign row_m[w] = m_q[rd_set];
    assign row_x[w] = x_q[rd_set];
    assign rd_m[w]  = mtch_to_word(m_q[sw_set]);
    assign rd_x[w]  = xlat_to_word(x_q[sw_set]);
  end

  always_comb begin
    case (sw_sel)
      SEL_MATCH: sw_rdata = rd_m[sw_way];
      SEL_XLAT:  sw_rdata = rd_x[sw_way];
      SEL_GEOM:  sw_rdata = geom_word();
      default:   sw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtlb_match.sv
module dtlb_match
  import dtlb_pkg::*;
(
  input  mtch_t             row_m [NUM_WAYS],
  input  xlat_t             row_x [NUM_WAYS],
  input  logic [TAG_W-1:0]  tag,
  input  logic              is_write,
  input  logic              is_super,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output xlat_t             hit_x,
  output logic              perm_ok
);
  logic [NUM_WAYS-1:0] way_hit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = row_m[w].valid && (row_m[w].tag == tag);
  end

  // ascending scan: the last matching way (highest index) is kept
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (way_hit[i]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(i);
      end
    end
  end

  assign hit_x = row_x[hit_way];

  always_comb begin
    case ({is_super, is_write})
      2'b11:   perm_ok = hit_x.swe;
      2'b10:   perm_ok = hit_x.sre;
      2'b01:   perm_ok = hit_x.uwe;
      default: perm_ok = hit_x.ure;
    endcase
  end
endmodule

// File: rtl/dtlb_resp.sv
module dtlb_resp
  import dtlb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [VA_W-1:0] vaddr,
  input  logic            xlate_on,
  input  logic            probe,
  input  logic            hit,
  input  xlat_t           hit_x,
  input  logic            perm_ok,
  output logic            rs_valid,
  output logic            rs_hit,
  output logic [VA_W-1:0] rs_paddr,
  output logic            rs_cinh,
  output logic            rs_pgfault,
  output logic            rs_miss,
  output logic [VA_W-1:0] rs_fault_addr
);
  logic            valid_n, hit_n, cinh_n, pf_n, miss_n;
  logic [VA_W-1:0] paddr_n, faddr_n;

  always_comb begin
    valid_n = req;
    hit_n   = 1'b0;
    cinh_n  = 1'b0;
    pf_n    = 1'b0;
    miss_n  = 1'b0;
    paddr_n = '0;
    if (req) begin
      if (!xlate_on) begin
        paddr_n = vaddr;
        cinh_n  = vaddr[VA_W-1];
      end else if (hit && (perm_ok || !probe)) begin
        hit_n   = 1'b1;
        paddr_n = {hit_x.ppn, vaddr[PAGE_BITS-1:0]};
        cinh_n  = hit_x.ci;
        pf_n    = !perm_ok;
      end else if (!hit) begin
        miss_n  = !probe;
      end
    end
    faddr_n = (pf_n || miss_n) ? vaddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid      <= 1'b0;
      rs_hit        <= 1'b0;
      rs_paddr      <= '0;
      rs_cinh       <= 1'b0;
      rs_pgfault    <= 1'b0;
      rs_miss       <= 1'b0;
      rs_fault_addr <= '0;
    end else begin
      rs_valid      <= valid_n;
      rs_hit        <= hit_n;
      rs_paddr      <= paddr_n;
      rs_cinh       <= cinh_n;
      rs_pgfault    <= pf_n;
      rs_miss       <= miss_n;
      rs_fault_addr <= faddr_n;
    end
  end
endmodule

// File: rtl/dtlb_top.sv
module dtlb_top
  import dtlb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_req,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic                lk_write,
  input  logic                lk_super,
  input  logic                lk_xlate_en,
  input  logic                lk_probe,
  output logic                rs_valid,
  output logic                rs_hit,
  output logic [VA_W-1:0]     rs_paddr,
  output logic                rs_cinh,
  output logic                rs_pgfault,
  output logic                rs_miss,
  output logic [VA_W-1:0]     rs_fault_addr,
  input  logic                sw_we,
  input  logic [1:0]          sw_sel,
  input  logic [WAY_W-1:0]    sw_way,
  input  logic [SET_BITS-1:0] sw_set,
  input  logic [VA_W-1:0]     sw_wdata,
  output logic [VA_W-1:0]     sw_rdata
);
  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic                xlate_on;
  mtch_t               row_m [NUM_WAYS];
  xlat_t               row_x [NUM_WAYS];
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  xlat_t               hit_x;
  logic                perm_ok;
  logic                upd_en;

  assign lk_set   = lk_vaddr[PAGE_BITS +: SET_BITS];
  assign lk_tag   = lk_vaddr[VA_W-1 -: TAG_W];
  assign xlate_on = lk_xlate_en && MMU_PRESENT;
  assign upd_en   = lk_req && xlate_on && hit && !lk_probe;

  dtlb_store u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(lk_set), .upd_en(upd_en), .upd_way(hit_way),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_way(sw_way), .sw_set(sw_set),
    .sw_wdata(sw_wdata), .row_m(row_m), .row_x(row_x), .sw_rdata(sw_rdata)
  );

  dtlb_match u_match (
    .row_m(row_m), .row_x(row_x), .tag(lk_tag), .is_write(lk_write),
    .is_super(lk_super), .hit(hit), .hit_way(hit_way), .hit_x(hit_x), .perm_ok(perm_ok)
  );

  dtlb_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req(lk_req), .vaddr(lk_vaddr), .xlate_on(xlate_on),
    .probe(lk_probe), .hit(hit), .hit_x(hit_x), .perm_ok(perm_ok),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_paddr(rs_paddr), .rs_cinh(rs_cinh),
    .rs_pgfault(rs_pgfault), .rs_miss(rs_miss), .rs_fault_addr(rs_fault_addr)
  );
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker
  import dtlb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                lk_req,
  input logic [VA_W-1:0]     lk_vaddr,
  input logic                lk_write,
  input logic                lk_super,
  input logic                lk_xlate_en,
  input logic                lk_probe,
  input logic                rs_valid,
  input logic                rs_hit,
  input logic [VA_W-1:0]     rs_paddr,
  input logic                rs_cinh,
  input logic                rs_pgfault,
  input logic                rs_miss,
  input logic [VA_W-1:0]     rs_fault_addr,
  input logic                sw_we,
  input logic [1:0]          sw_sel,
  input logic [WAY_W-1:0]    sw_way,
  input logic [SET_BITS-1:0] sw_set,
  input logic [VA_W-1:0]     sw_wdata,
  input logic [VA_W-1:0]     sw_rdata
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (rs_valid == $past(lk_req)));

  // R1
  bypass_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(lk_req && !lk_xlate_en)) |->
      (rs_paddr == $past(lk_vaddr) && rs_cinh == $past(lk_vaddr[VA_W-1])
       && !rs_hit && !rs_miss && !rs_pgfault));

  // R9
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(lk_req && lk_probe)) |-> (!rs_pgfault && !rs_miss));

  // R7
  miss_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rs_miss) |-> (!rs_hit && rs_paddr == '0 && rs_fault_addr == $past(lk_vaddr)));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rs_hit) |-> (rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));

  // R6
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rs_pgfault) |-> (rs_hit && !rs_miss && rs_fault_addr == $past(lk_vaddr)));
endmodule

bind dtlb_top dtlb_checker u_chk (.*);

// File: tb/dtlb_top_test.sv
module dtlb_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0, lk_super = 1'b0, lk_xlate_en = 1'b0, lk_probe = 1'b0;
  logic        rs_valid, rs_hit, rs_cinh, rs_pgfault, rs_miss;
  logic [31:0] rs_paddr, rs_fault_addr, sw_rdata;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [0:0]  sw_way = '0;
  logic [5:0]  sw_set = '0;
  logic [31:0] sw_wdata = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dtlb_top uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_super(lk_super), .lk_xlate_en(lk_xlate_en), .lk_probe(lk_probe),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_paddr(rs_paddr), .rs_cinh(rs_cinh),
    .rs_pgfault(rs_pgfault), .rs_miss(rs_miss), .rs_fault_addr(rs_fault_addr),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_way(sw_way), .sw_set(sw_set),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL R10 watchdog: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  op;    // 0 match write, 1 translate write, 2 lookup, 3 probe
    logic        way;
    logic [5:0]  set;
    logic [31:0] data;  // write data or virtual address
    logic        wr, sup, en;
    logic [31:0] e_pa;
    logic        e_hit, e_ci, e_pf, e_miss;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,6'd5, 32'h00480001,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{2'd1,1'b0,6'd5, 32'h12345036,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{2'd0,1'b1,6'd5, 32'h004C0001,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{2'd1,1'b1,6'd5, 32'h0007703C,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{2'd0,1'b0,6'd12,32'h01000001,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{2'd1,1'b0,6'd12,32'h44444008,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd6},
    // R5 user read, inhibited page
    '{2'd2,1'b0,6'd0, 32'h00485ABC,1'b0,1'b0,1'b1,32'h12345ABC,1'b1,1'b1,1'b0,1'b0,4'd5},
    // R6 user write without user-write bit
    '{2'd2,1'b0,6'd0, 32'h00485ABC,1'b1,1'b0,1'b1,32'h12345ABC,1'b1,1'b1,1'b1,1'b0,4'd6},
    '{2'd2,1'b0,6'd0, 32'h00485ABC,1'b1,1'b1,1'b1,32'h12345ABC,1'b1,1'b1,1'b0,1'b0,4'd6},
    '{2'd2,1'b0,6'd0, 32'h00485ABC,1'b0,1'b1,1'b1,32'h12345ABC,1'b1,1'b1,1'b0,1'b0,4'd6},
    // R2 other way of same set
    '{2'd2,1'b0,6'd0, 32'h004C5010,1'b1,1'b0,1'b1,32'h00077010,1'b1,1'b0,1'b0,1'b0,4'd2},
    // R2 same tag, other set
    '{2'd2,1'b0,6'd0, 32'h00486ABC,1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,1'b0,1'b1,4'd2},
    // R7 plain miss
    '{2'd2,1'b0,6'd0, 32'h00505000,1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,1'b0,1'b1,4'd7},
    // R6 write-only user page
    '{2'd2,1'b0,6'd0, 32'h0100C010,1'b0,1'b0,1'b1,32'h44444010,1'b1,1'b0,1'b1,1'b0,4'd6},
    '{2'd2,1'b0,6'd0, 32'h0100C010,1'b1,1'b0,1'b1,32'h44444010,1'b1,1'b0,1'b0,1'b0,4'd6},
    '{2'd2,1'b0,6'd0, 32'h0100C010,1'b0,1'b1,1'b1,32'h44444010,1'b1,1'b0,1'b1,1'b0,4'd6},
    // R1 bypass
    '{2'd2,1'b0,6'd0, 32'h80001234,1'b0,1'b0,1'b0,32'h80001234,1'b0,1'b1,1'b0,1'b0,4'd1},
    '{2'd2,1'b0,6'd0, 32'h7FFFFFFF,1'b1,1'b1,1'b0,32'h7FFFFFFF,1'b0,1'b0,1'b0,1'b0,4'd1},
    // R9 probes
    '{2'd3,1'b0,6'd0, 32'h00485ABC,1'b1,1'b0,1'b1,32'h0,1'b0,1'b0,1'b0,1'b0,4'd9},
    '{2'd3,1'b0,6'd0, 32'h00505000,1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,1'b0,1'b0,4'd9},
    '{2'd3,1'b0,6'd0, 32'h00485ABC,1'b0,1'b0,1'b1,32'h12345ABC,1'b1,1'b1,1'b0,1'b0,4'd9},
    '{2'd0,1'b0,6'd9, 32'h00800001,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd4},
    '{2'd1,1'b0,6'd9, 32'h1111103C,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd4},
    '{2'd0,1'b1,6'd9, 32'h00800001,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd4},
    '{2'd1,1'b1,6'd9, 32'h2222203C,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd4},
    // R4 duplicate tag, way 1 wins
    '{2'd2,1'b0,6'd0, 32'h00809044,1'b0,1'b0,1'b1,32'h22222044,1'b1,1'b0,1'b0,1'b0,4'd4},
    '{2'd0,1'b0,6'd3, 32'h00C00000,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{2'd1,1'b0,6'd3, 32'h3333303C,1'b0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,4'd3},
    // R3 tag matches but valid clear
    '{2'd2,1'b0,6'd0, 32'h00C03000,1'b0,1'b0,1'b1,32'h0,1'b0,1'b0,1'b0,1'b1,4'd3}
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic way, input logic [5:0] set, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_way = way; sw_set = set; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [1:0] sel, input logic way, input logic [5:0] set, output logic [31:0] d);
    @(negedge clk);
    sw_sel = sel; sw_way = way; sw_set = set;
    #1 d = sw_rdata;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic sup, input logic en, input logic pr);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr; lk_super = sup; lk_xlate_en = en; lk_probe = pr;
    @(negedge clk);
    lk_req = 1'b0; lk_probe = 1'b0;
  endtask

  task automatic expect_res(input string rq, input logic [31:0] va, input logic [31:0] pa,
                            input logic h, input logic ci, input logic pf, input logic ms);
    logic [31:0] fa;
    fa = (pf || ms) ? va : 32'h0;
    check(rs_valid && rs_paddr == pa && rs_hit == h && rs_cinh == ci && rs_pgfault == pf
          && rs_miss == ms && rs_fault_addr == fa, rq,
          {rs_valid, rs_hit, rs_cinh, rs_pgfault, rs_miss, rs_paddr[26:0]},
          {1'b1, h, ci, pf, ms, pa[26:0]});
    if (rs_fault_addr != fa) check(1'b0, rq, rs_fault_addr, fa);
  endtask

  task automatic lru_read(input string rq, input logic way, input logic [31:0] exp);
    logic [31:0] d;
    sw_read(2'd0, way, 6'd7, d);
    check(d == exp, rq, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(!rs_valid && !rs_hit && !rs_miss && !rs_pgfault && rs_paddr == 0, "R13", {27'b0, rs_valid, rs_hit, rs_miss, rs_pgfault, rs_cinh}, 32'h0);
    sw_read(2'd0, 1'b0, 6'd5, d);
    check(d == 32'h0, "R13 entry", d, 32'h0);
    // R12 geometry
    sw_read(2'd2, 1'b0, 6'd0, d);
    check(d == 32'h16, "R12", d, 32'h16);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op < 2'd2) begin
        sw_write(TBL[i].op, TBL[i].way, TBL[i].set, TBL[i].data);
      end else begin
        lookup(TBL[i].data, TBL[i].wr, TBL[i].sup, TBL[i].en, TBL[i].op == 2'd3);
        expect_res($sformatf("R%0d row%0d", TBL[i].rq, i), TBL[i].data, TBL[i].e_pa,
                   TBL[i].e_hit, TBL[i].e_ci, TBL[i].e_pf, TBL[i].e_miss);
      end
    end

    // R12 readback of a translate word
    sw_read(2'd1, 1'b0, 6'd5, d);
    check(d == 32'h12345036, "R12 xlat readback", d, 32'h12345036);

    // R10 pulses last one cycle
    lookup(32'h00505000, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check(!rs_valid && !rs_miss && rs_fault_addr == 0, "R10 pulse", {30'b0, rs_valid, rs_miss}, 32'h0);

    // R11 write and lookup in the same cycle
    sw_write(2'd1, 1'b0, 6'd11, 32'h5555503C);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = 2'd0; sw_way = 1'b0; sw_set = 6'd11; sw_wdata = 32'h0140_0001;
    lk_req = 1'b1; lk_vaddr = 32'h0140B000; lk_write = 1'b0; lk_super = 1'b0; lk_xlate_en = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; lk_req = 1'b0;
    expect_res("R11 same cycle", 32'h0140B000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    lookup(32'h0140B000, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_res("R11 next cycle", 32'h0140B000, 32'h55555000, 1'b1, 1'b0, 1'b0, 1'b0);

    // R8 usage counters on set 7
    sw_write(2'd0, 1'b0, 6'd7, 32'h00040001);
    sw_write(2'd1, 1'b0, 6'd7, 32'h0000003C);
    sw_write(2'd0, 1'b1, 6'd7, 32'h00080005);
    sw_write(2'd1, 1'b1, 6'd7, 32'h0000003C);
    lookup(32'h00047000, 1'b0, 1'b0, 1'b1, 1'b0);
    lru_read("R8 hit way load", 1'b0, 32'h00040007);
    lru_read("R8 other way dec", 1'b1, 32'h00080003);
    lookup(32'h00087000, 1'b0, 1'b0, 1'b1, 1'b1);
    lru_read("R9 probe keeps lru", 1'b1, 32'h00080003);
    lru_read("R9 probe keeps lru other", 1'b0, 32'h00040007);
    lookup(32'h00087000, 1'b0, 1'b0, 1'b1, 1'b0);
    lru_read("R8 reload", 1'b1, 32'h00080007);
    lru_read("R8 dec to 2", 1'b0, 32'h00040005);
    lookup(32'h00087000, 1'b0, 1'b0, 1'b1, 1'b0);
    lookup(32'h00087000, 1'b0, 1'b0, 1'b1, 1'b0);
    lru_read("R8 dec to 0", 1'b0, 32'h00040001);
    lookup(32'h00087000, 1'b0, 1'b0, 1'b1, 1'b0);
    lru_read("R8 saturate", 1'b0, 32'h00040001);

    // R13 reset clears entries
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    sw_read(2'd0, 1'b0, 6'd5, d);
    check(d == 32'h0, "R13 cleared", d, 32'h0);
    lookup(32'h00485ABC, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_res("R13 miss after reset", 32'h00485ABC, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule